// File: doc/BRIEF.md
# Parallel Response Signature Compactor

This block folds several parallel response bits from a circuit under test into one short signature. On every enabled clock, each stage of a modular linear feedback register takes its upstream neighbour, adds the fed-back top stage where the polynomial has a tap, and then XORs in its own data bit. One register therefore serves every monitored output. Because all operations are XOR, the result after a run is the XOR of the signatures that each output would have left on its own.

A test controller clears the register or loads a seed, then streams responses with the enable held high. At the end it compares the signature with the known fault-free value through the expected input and the match flag. A faulty response can still leave the good signature behind, and the chance of that falls as about 2^-n with register width n. It is roughly 6.25 % at four bits and 0.39 % at eight. The default instance is three bits wide with characteristic polynomial 1 + X + X^3.

Top module: `misr_compactor`

## Requirements
- R1: When `rst` is high at a rising clock edge, `signature` becomes all zeros and `match` becomes 0 after that edge, whatever the other inputs are.
- R2: When `rst` is low and `seed_load` is high at an edge, `signature` takes `seed_value` after that edge.
- R3: When `rst`, `seed_load` and `enable` are all low at an edge, `signature` keeps its value, and `data_in` has no effect on it.
- R4: When `enable` is high and `rst` and `seed_load` are low, the 3-bit instance updates as follows, where bit 0 is the stage fed from the top stage: s0 <= s2 ^ d0, s1 <= s0 ^ s2 ^ d1, s2 <= s1 ^ d2.
- R5: Starting from an all-zero signature, the signature after a data sequence equals the XOR of the signatures obtained by running each `data_in` bit's stream alone, with the other bits held at zero.
- R6: After every edge at which `rst` is low, `match` is 1 exactly when the new `signature` equals the `expected` value sampled at that edge.
- R7: With `data_in` at zero and `enable` high, any nonzero seed returns after exactly 7 updates without passing through itself or zero in between. An all-zero signature stays at zero.
- R8: `seed_load` takes priority over `enable`. A load and an enable at the same edge give the seed, not an update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| seed_load | input | 1 | Load `seed_value` into the register |
| seed_value | input | WIDTH | Initial register contents |
| enable | input | 1 | Perform one compaction step |
| data_in | input | WIDTH | Parallel response bits, bit i enters stage i |
| expected | input | WIDTH | Fault-free signature for comparison |
| signature | output | WIDTH | Current register contents |
| match | output | 1 | Registered equality of signature and expected |

## Verification
The match check assumes that `expected` is a plain level sampled at each edge. It therefore compares the flag with the value present at the previous edge, and the stimulus holds `expected` steady through each scenario. The hold and load checks assume that the control inputs change only between edges. The bench drives every input on the falling edge, one half period away from the sampling edge. The all-zero check assumes that nothing but `data_in` can bring in ones, so the bench keeps `seed_load` low in those windows.

// File: rtl/misr_pkg.sv
package misr_pkg;

  // Action applied to every stage at the next rising edge
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_SEED  = 2'd2,
    OP_CLEAR = 2'd3
  } misr_op_e;

endpackage

// File: rtl/misr_ctrl.sv
module misr_ctrl
  import misr_pkg::*;
(
  input  logic     rst,
  input  logic     seed_load,
  input  logic     enable,
  output misr_op_e op
);

  // Fixed priority: clear, then seed, then shift, otherwise hold
  always_comb begin
    if (rst)            op = OP_CLEAR;
    else if (seed_load) op = OP_SEED;
    else if (enable)    op = OP_SHIFT;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/misr_stage.sv
module misr_stage
  import misr_pkg::*;
#(
  parameter logic TAP = 1'b0
) (
  input  logic     clk,
  input  misr_op_e op,
  input  logic     prev_bit,
  input  logic     fb_bit,
  input  logic     data_bit,
  input  logic     seed_bit,
  output logic     next_bit,
  output logic     q
);

  logic shift_val;

  generate
    if (TAP) begin : g_tap
      assign shift_val = prev_bit ^ fb_bit ^ data_bit;
    end else begin : g_notap
      assign shift_val = prev_bit ^ data_bit;
    end
  endgenerate

  always_comb begin
    case (op)
      OP_CLEAR: next_bit = 1'b0;
      OP_SEED:  next_bit = seed_bit;
      OP_SHIFT: next_bit = shift_val;
      default:  next_bit = q;
    endcase
  end

  always_ff @(posedge clk) begin
    q <= next_bit;
  end

endmodule

// File: rtl/misr_match.sv
module misr_match
  import misr_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  misr_op_e         op,
  input  logic [WIDTH-1:0] sig_next,
  input  logic [WIDTH-1:0] sig_q,
  input  logic [WIDTH-1:0] expected,
  output logic             match
);

  always_ff @(posedge clk) begin
    if (op == OP_CLEAR) match <= 1'b0;
    else                match <= (sig_next == expected);
  end

  // R6
  match_expected_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (match == (sig_q == $past(expected))));

endmodule

// File: rtl/misr_compactor.sv
module misr_compactor
  import misr_pkg::*;
#(
  parameter int             WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 3'b011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  input  logic             enable,
  input  logic [WIDTH-1:0] data_in,
  input  logic [WIDTH-1:0] expected,
  output logic [WIDTH-1:0] signature,
  output logic             match
);

  localparam int MSB = WIDTH - 1;

  misr_op_e         op;
  logic [WIDTH-1:0] sig_q;
  logic [WIDTH-1:0] sig_next;

  misr_ctrl u_ctrl (
    .rst       (rst),
    .seed_load (seed_load),
    .enable    (enable),
    .op        (op)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic prev_bit;
      if (i == 0) begin : g_head
        assign prev_bit = 1'b0;
      end else begin : g_body
        assign prev_bit = sig_q[i-1];
      end
      misr_stage #(.TAP(TAP_MASK[i])) u_stage (
        .clk      (clk),
        .op       (op),
        .prev_bit (prev_bit),
        .fb_bit   (sig_q[MSB]),
        .data_bit (data_in[i]),
        .seed_bit (seed_value[i]),
        .next_bit (sig_next[i]),
        .q        (sig_q[i])
      );
    end
  endgenerate

  misr_match #(.WIDTH(WIDTH)) u_match (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .sig_next (sig_next),
    .sig_q    (sig_q),
    .expected (expected),
    .match    (match)
  );

  assign signature = sig_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (signature == '0 && !match));

  // R2 R8
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (signature == $past(seed_value)));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !enable) |=> $stable(signature));

  // R7
  zero_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !seed_load && signature == '0 && data_in == '0) |=> (signature == '0));

endmodule

// File: tb/tb_misr_compactor.sv
`timescale 1ns/1ps
module tb_misr_compactor;

  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst;
  logic         seed_load;
  logic [W-1:0] seed_value;
  logic         enable;
  logic [W-1:0] data_in;
  logic [W-1:0] expected;
  logic [W-1:0] signature;
  logic         match;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] model;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  misr_compactor dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .enable(enable), .data_in(data_in), .expected(expected),
    .signature(signature), .match(match)
  );

  // Update rule taken from R4
  function automatic logic [W-1:0] upd(input logic [W-1:0] s, input logic [W-1:0] d);
    upd = {s[1] ^ d[2], s[0] ^ s[2] ^ d[1], s[2] ^ d[0]};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One clock with the given controls; inputs change on the falling edge
  task automatic tick(input logic r, input logic ld, input logic en, input logic [W-1:0] d);
    @(negedge clk);
    rst = r; seed_load = ld; enable = en; data_in = d;
    @(posedge clk);
    #1;
    if (r) model = '0;
    else if (ld) model = seed_value;
    else if (en) model = upd(model, d);
  endtask

  task automatic do_reset();
    tick(1'b1, 1'b0, 1'b0, '0);
    tick(1'b1, 1'b1, 1'b1, 3'b111);
    tick(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic test_reset();
    seed_value = 3'b101;
    tick(1'b0, 1'b1, 1'b0, '0);
    tick(1'b1, 1'b1, 1'b1, 3'b110);
    chk("R1 signature clear", signature, 3'b000);
    chk("R1 match low", {2'b0, match}, 3'b000);
  endtask

  task automatic test_load_and_hold();
    seed_value = 3'b110;
    tick(1'b0, 1'b1, 1'b0, 3'b011);
    chk("R2 seed loaded", signature, 3'b110);
    for (int k = 0; k < 4; k++) begin
      tick(1'b0, 1'b0, 1'b0, 3'(k * 3 + 1));
      chk("R3 hold ignores data", signature, 3'b110);
    end
  endtask

  task automatic test_priority();
    seed_value = 3'b011;
    tick(1'b0, 1'b1, 1'b1, 3'b111);
    chk("R8 load beats enable", signature, 3'b011);
  endtask

  task automatic test_steps();
    seed_value = 3'b000;
    tick(1'b0, 1'b1, 1'b0, '0);
    for (int k = 0; k < 8; k++) begin
      tick(1'b0, 1'b0, 1'b1, 3'((k * 5 + 3) % 8));
      chk("R4 update", signature, model);
    end
    tick(1'b0, 1'b0, 1'b1, 3'b001);
    chk("R4 update single", signature, model);
  endtask

  function automatic logic [W-1:0] stream(input int k);
    stream = 3'((k * 7 + k / 3 + 2) % 8);
  endfunction

  task automatic run_stream(input logic [W-1:0] mask, output logic [W-1:0] res);
    seed_value = '0;
    tick(1'b0, 1'b1, 1'b0, '0);
    for (int k = 0; k < 9; k++) tick(1'b0, 1'b0, 1'b1, stream(k) & mask);
    res = signature;
  endtask

  task automatic test_superposition();
    logic [W-1:0] s0, s1, s2, sall, ref_all;
    run_stream(3'b001, s0);
    run_stream(3'b010, s1);
    run_stream(3'b100, s2);
    run_stream(3'b111, sall);
    ref_all = '0;
    for (int k = 0; k < 9; k++) ref_all = upd(ref_all, stream(k));
    chk("R5 xor of single streams", sall, s0 ^ s1 ^ s2);
    chk("R5 combined vs rule", sall, ref_all);
  endtask

  task automatic test_period();
    seed_value = 3'b001;
    tick(1'b0, 1'b1, 1'b0, '0);
    for (int k = 1; k <= 7; k++) begin
      tick(1'b0, 1'b0, 1'b1, '0);
      if (k < 7) begin
        n_checks++;
        if (signature == 3'b001 || signature == 3'b000) begin
          n_fail++;
          $display("FAIL R7: actual %b expected not 001/000 at step %0d", signature, k);
        end
      end
    end
    chk("R7 period seven", signature, 3'b001);
    seed_value = '0;
    tick(1'b0, 1'b1, 1'b0, '0);
    for (int k = 0; k < 3; k++) tick(1'b0, 1'b0, 1'b1, '0);
    chk("R7 zero stays zero", signature, 3'b000);
  endtask

  task automatic test_match();
    logic [W-1:0] target;
    target = '0;
    for (int k = 0; k < 5; k++) target = upd(target, 3'(k + 2));
    expected = target;
    seed_value = '0;
    tick(1'b0, 1'b1, 1'b0, '0);
    for (int k = 0; k < 5; k++) begin
      tick(1'b0, 1'b0, 1'b1, 3'(k + 2));
      chk("R6 match flag", {2'b0, match}, {2'b0, (model == expected)});
    end
    chk("R6 good signature matches", {2'b0, match}, 3'b001);
    tick(1'b0, 1'b0, 1'b1, 3'b100);
    chk("R6 match follows", {2'b0, match}, {2'b0, (model == expected)});
    expected = ~model;
    tick(1'b0, 1'b0, 1'b0, '0);
    chk("R6 mismatch low", {2'b0, match}, 3'b000);
  endtask

  initial begin
    rst = 1'b1; seed_load = 1'b0; enable = 1'b0; data_in = '0;
    seed_value = '0; expected = 3'b111; model = '0;
    do_reset();
    chk("R1 reset state", signature, 3'b000);
    chk("R1 reset match", {2'b0, match}, 3'b000);
    test_reset();
    test_load_and_hold();
    test_priority();
    test_steps();
    test_superposition();
    test_period();
    test_match();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule